// File: doc/BRIEF.md
# Configurable Pin Input/Output Cell Bank

This block is a bank of identical pin cells, one per pad, that sit between a logic array and the chip's pads. Each cell is set up by its own configuration bits. It can behave as a plain input, an input captured by a flop, an input held by a level-sensitive latch, a driven output, or a bidirectional pin whose driver is switched on and off.

On the pad side each lane has a data value, a driver enable and a received value. On the array side it takes output data and a local enable term, and it returns the input value. A dedicated I/O clock times the capture flop and the latch. One global output-enable line can replace the local enable term for any lane that selects it. An active-low global reset clears the stored input state. A per-lane slow-edge flag is passed to the pad unchanged. The pad uses that flag to shape its edges, which is outside this block.

Top module: `io_cell_bank`

## Requirements
- R1: Mode code 3'b000 (combinational input) gives `core_din` equal to `pad_in` in the same cycle.
- R2: Mode code 3'b001 (registered input) gives `core_din` equal to the `pad_in` value sampled at the most recent rising edge of `io_clk`. It is stable between edges.
- R3: Mode code 3'b010 (latched input) gives `core_din` that follows `pad_in` while `io_clk` is high. It keeps the value present at the falling edge while `io_clk` is low.
- R4: In the three input-only modes (000, 001, 010), `pad_oe` is 0 and `pad_out` is 0, whatever `core_oe`, `glob_oe` and `cfg_oe_glob` are.
- R5: Mode code 3'b011 (output) drives the pad unconditionally: `pad_oe` = 1, `pad_out` = `core_dout`, and `core_din` = 0.
- R6: Mode code 3'b100 (bidirectional) gives `pad_oe` equal to `glob_oe` when the lane's `cfg_oe_glob` bit is 1, and equal to `core_oe` when that bit is 0. Whenever `pad_oe` is 1, `pad_out` equals `core_dout`; otherwise `pad_out` is 0.
- R7: In bidirectional mode, `core_din` equals `pad_in`, including while the lane is driving.
- R8: Mode codes 3'b101, 3'b110 and 3'b111 disable the driver (`pad_oe` = 0, `pad_out` = 0) and pass `pad_in` to `core_din` combinationally.
- R9: While `rst_n` is 0, the capture flop and latch are cleared at once, without waiting for a clock. `core_din` therefore reads 0 in registered and latched modes.
- R10: `pad_slow` equals `cfg_slow` on every lane, in every mode.

Lane i uses bits [3i+2:3i] of `cfg_mode` and bit i of every other vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk | input | 1 | I/O capture clock for the flop and the latch |
| rst_n | input | 1 | Active-low global reset of the capture state |
| glob_oe | input | 1 | Global output enable |
| cfg_mode | input | 3*LANES | Per-lane mode code |
| cfg_oe_glob | input | LANES | 1: lane uses glob_oe; 0: lane uses core_oe |
| cfg_slow | input | LANES | Per-lane slow-edge select |
| core_dout | input | LANES | Output data from the array |
| core_oe | input | LANES | Local output-enable term from the array |
| core_din | output | LANES | Input data to the array |
| pad_in | input | LANES | Value received from the pad |
| pad_out | output | LANES | Value driven to the pad |
| pad_oe | output | LANES | Pad driver enable |
| pad_slow | output | LANES | Slow-edge flag to the pad |

## Verification
The clocked properties sample on rising `io_clk` edges and assume `pad_in` and the configuration change well away from those edges. The bench respects this by moving every input one or more time units after an edge. The registered-input property also assumes the previous edge fell outside reset. It is guarded with the past value of `rst_n`, and the bench always releases reset on a falling edge. Latch transparency depends on the clock level, so it is checked only by the bench, which alters `pad_in` inside a known phase of `io_clk`.

// File: rtl/io_cell_pkg.sv
package io_cell_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    IOM_COMB  = 3'b000,
    IOM_REG   = 3'b001,
    IOM_LATCH = 3'b010,
    IOM_OUT   = 3'b011,
    IOM_BIDIR = 3'b100
  } io_mode_e;

  // Input-only modes never drive the pad.
  function automatic logic mode_is_input(input logic [MODE_W-1:0] m);
    return (m == IOM_COMB) || (m == IOM_REG) || (m == IOM_LATCH);
  endfunction

  // Driver enable for one lane.
  function automatic logic drive_enable(input logic [MODE_W-1:0] m,
                                        input logic use_glob,
                                        input logic loc_oe,
                                        input logic g_oe);
    logic en;
    case (m)
      IOM_OUT:   en = 1'b1;
      IOM_BIDIR: en = use_glob ? g_oe : loc_oe;
      default:   en = 1'b0;
    endcase
    return en;
  endfunction

  // Value returned to the array.
  function automatic logic pick_input(input logic [MODE_W-1:0] m,
                                      input logic pad,
                                      input logic flop_q,
                                      input logic latch_q);
    logic v;
    case (m)
      IOM_REG:   v = flop_q;
      IOM_LATCH: v = latch_q;
      IOM_OUT:   v = 1'b0;
      default:   v = pad;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/io_capture.sv
module io_capture (
  input  logic io_clk,
  input  logic rst_n,
  input  logic d,
  output logic flop_q,
  output logic latch_q
);

  always_ff @(posedge io_clk or negedge rst_n) begin
    if (!rst_n) flop_q <= 1'b0;
    else        flop_q <= d;
  end

  // Transparent while io_clk is high.
  always_latch begin
    if (!rst_n)      latch_q <= 1'b0;
    else if (io_clk) latch_q <= d;
  end

endmodule

// File: rtl/io_driver.sv
module io_driver
  import io_cell_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              use_glob,
  input  logic              loc_oe,
  input  logic              g_oe,
  input  logic              dout,
  output logic              oe,
  output logic              drv
);

  always_comb begin
    oe  = drive_enable(mode, use_glob, loc_oe, g_oe);
    drv = oe & dout;
  end

endmodule

// File: rtl/io_lane.sv
module io_lane
  import io_cell_pkg::*;
(
  input  logic              io_clk,
  input  logic              rst_n,
  input  logic              glob_oe,
  input  logic [MODE_W-1:0] mode,
  input  logic              use_glob,
  input  logic              slow,
  input  logic              dout,
  input  logic              loc_oe,
  input  logic              pad_in,
  output logic              din,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pad_slow
);

  logic flop_q;
  logic latch_q;
  logic input_only;

  io_capture u_cap (
    .io_clk (io_clk),
    .rst_n  (rst_n),
    .d      (pad_in),
    .flop_q (flop_q),
    .latch_q(latch_q)
  );

  io_driver u_drv (
    .mode    (mode),
    .use_glob(use_glob),
    .loc_oe  (loc_oe),
    .g_oe    (glob_oe),
    .dout    (dout),
    .oe      (pad_oe),
    .drv     (pad_out)
  );

  always_comb begin
    input_only = mode_is_input(mode);
    din        = pick_input(mode, pad_in, flop_q, latch_q);
  end

  assign pad_slow = slow;

  p_reg_capture_r2: assert property (@(posedge io_clk) disable iff (!rst_n)
    (mode == IOM_REG && $past(rst_n)) |-> (din == $past(pad_in)))
    else $error("registered input lost its sample");

  p_input_hiz_r4: assert property (@(posedge io_clk) disable iff (!rst_n)
    input_only |-> (!pad_oe && !pad_out))
    else $error("input-only lane drives the pad");

  p_out_drive_r5: assert property (@(posedge io_clk) disable iff (!rst_n)
    (mode == IOM_OUT) |-> (pad_oe && pad_out == dout && !din))
    else $error("output mode not driving");

  p_bidir_sel_r6: assert property (@(posedge io_clk) disable iff (!rst_n)
    (mode == IOM_BIDIR) |-> (pad_oe == (use_glob ? glob_oe : loc_oe)))
    else $error("bidirectional enable source wrong");

  p_bidir_echo_r7: assert property (@(posedge io_clk) disable iff (!rst_n)
    (mode == IOM_BIDIR) |-> (din == pad_in))
    else $error("bidirectional input path wrong");

  p_spare_off_r8: assert property (@(posedge io_clk) disable iff (!rst_n)
    (mode > IOM_BIDIR) |-> (!pad_oe && din == pad_in))
    else $error("spare code misbehaves");

  p_slow_pass_r10: assert property (@(posedge io_clk) disable iff (!rst_n)
    pad_slow == slow)
    else $error("slew flag not forwarded");

endmodule

// File: rtl/io_cell_bank.sv
module io_cell_bank
  import io_cell_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    io_clk,
  input  logic                    rst_n,
  input  logic                    glob_oe,
  input  logic [MODE_W*LANES-1:0] cfg_mode,
  input  logic [LANES-1:0]        cfg_oe_glob,
  input  logic [LANES-1:0]        cfg_slow,
  input  logic [LANES-1:0]        core_dout,
  input  logic [LANES-1:0]        core_oe,
  output logic [LANES-1:0]        core_din,
  input  logic [LANES-1:0]        pad_in,
  output logic [LANES-1:0]        pad_out,
  output logic [LANES-1:0]        pad_oe,
  output logic [LANES-1:0]        pad_slow
);

  localparam int CFG_W = MODE_W * LANES;

  logic [CFG_W-1:0] mode_bus;
  assign mode_bus = cfg_mode;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    io_lane u_lane (
      .io_clk  (io_clk),
      .rst_n   (rst_n),
      .glob_oe (glob_oe),
      .mode    (mode_bus[i*MODE_W +: MODE_W]),
      .use_glob(cfg_oe_glob[i]),
      .slow    (cfg_slow[i]),
      .dout    (core_dout[i]),
      .loc_oe  (core_oe[i]),
      .pad_in  (pad_in[i]),
      .din     (core_din[i]),
      .pad_out (pad_out[i]),
      .pad_oe  (pad_oe[i]),
      .pad_slow(pad_slow[i])
    );
  end

endmodule

// File: tb/tb_io_cell_bank.sv
module tb_io_cell_bank;

  localparam int L = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          glob_oe = 1'b0;
  logic [3*L-1:0] cfg_mode = '0;
  logic [L-1:0]  cfg_oe_glob = '0, cfg_slow = '0, core_dout = '0, core_oe = '0, pad_in = '0;
  logic [L-1:0]  core_din, pad_out, pad_oe, pad_slow;

  io_cell_bank #(.LANES(L)) dut (
    .io_clk(clk), .rst_n(rst_n), .glob_oe(glob_oe), .cfg_mode(cfg_mode),
    .cfg_oe_glob(cfg_oe_glob), .cfg_slow(cfg_slow), .core_dout(core_dout),
    .core_oe(core_oe), .core_din(core_din), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_slow(pad_slow)
  );

  always #5 clk = ~clk;

  typedef struct {
    string      req;
    logic [3:0] din;
    logic [3:0] oe;
    logic [3:0] out;
    logic [3:0] slow;
  } exp_t;

  exp_t sb[$];
  event sample_ev;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  function automatic logic [11:0] m4(logic [2:0] a3, logic [2:0] a2,
                                     logic [2:0] a1, logic [2:0] a0);
    return {a3, a2, a1, a0};
  endfunction

  // Driver side: queue the expectation and wake the monitor.
  task automatic expect_now(string r, logic [3:0] d, logic [3:0] o,
                            logic [3:0] p, logic [3:0] s);
    exp_t e;
    e.req = r; e.din = d; e.oe = o; e.out = p; e.slow = s;
    sb.push_back(e);
    ->sample_ev;
    #2;
  endtask

  // Monitor side.
  initial begin
    forever begin
      @(sample_ev);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (core_din !== e.din || pad_oe !== e.oe || pad_out !== e.out || pad_slow !== e.slow) begin
          n_bad++;
          $display("FAIL %s: din/oe/out/slow got %b/%b/%b/%b expected %b/%b/%b/%b",
                   e.req, core_din, pad_oe, pad_out, pad_slow, e.din, e.oe, e.out, e.slow);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: stored state is zero while in reset
    cfg_mode = m4(3'd2, 3'd1, 3'd2, 3'd1);
    pad_in = 4'hF; cfg_slow = 4'b1010;
    #12;
    expect_now("R9 reset", 4'b0000, 4'b0000, 4'b0000, 4'b1010);

    // R1/R4: combinational input, driver off despite enables
    @(negedge clk);
    rst_n = 1'b1;
    cfg_mode = m4(3'd0, 3'd0, 3'd0, 3'd0);
    pad_in = 4'b1010; core_oe = 4'hF; glob_oe = 1'b1; cfg_oe_glob = 4'b0101; core_dout = 4'hF;
    #1;
    expect_now("R1 R4 comb", 4'b1010, 4'b0000, 4'b0000, 4'b1010);

    // R2: registered input
    @(posedge clk); #2;
    pad_in = 4'b0110; cfg_mode = m4(3'd1, 3'd1, 3'd1, 3'd1);
    #1;
    expect_now("R2 old sample", 4'b1010, 4'b0000, 4'b0000, 4'b1010);
    @(posedge clk); #2;
    expect_now("R2 new sample", 4'b0110, 4'b0000, 4'b0000, 4'b1010);
    pad_in = 4'b1001;
    #1;
    expect_now("R2 mid-cycle hold", 4'b0110, 4'b0000, 4'b0000, 4'b1010);

    // R3: latched input
    @(posedge clk); #1;
    cfg_mode = m4(3'd2, 3'd2, 3'd2, 3'd2); pad_in = 4'b0011;
    #1;
    expect_now("R3 transparent", 4'b0011, 4'b0000, 4'b0000, 4'b1010);
    @(negedge clk); #1;
    pad_in = 4'b1100;
    #1;
    expect_now("R3 hold low", 4'b0011, 4'b0000, 4'b0000, 4'b1010);
    @(posedge clk); #1;
    expect_now("R3 reopen", 4'b1100, 4'b0000, 4'b0000, 4'b1010);

    // R5: output mode
    @(negedge clk); #1;
    cfg_mode = m4(3'd3, 3'd3, 3'd3, 3'd3);
    core_dout = 4'b0101; core_oe = 4'b0000; glob_oe = 1'b0; pad_in = 4'hF;
    #1;
    expect_now("R5 output", 4'b0000, 4'b1111, 4'b0101, 4'b1010);

    // R6/R7: bidirectional, local enable
    @(negedge clk); #1;
    cfg_mode = m4(3'd4, 3'd4, 3'd4, 3'd4);
    cfg_oe_glob = 4'b0000; core_oe = 4'b0011; core_dout = 4'b1110; pad_in = 4'b1001;
    #1;
    expect_now("R6 R7 local oe", 4'b1001, 4'b0011, 4'b0010, 4'b1010);

    // R6: global enable
    cfg_oe_glob = 4'b1111; glob_oe = 1'b1; core_oe = 4'b0000;
    #1;
    expect_now("R6 global on", 4'b1001, 4'b1111, 4'b1110, 4'b1010);
    glob_oe = 1'b0;
    #1;
    expect_now("R6 global off", 4'b1001, 4'b0000, 4'b0000, 4'b1010);
    cfg_oe_glob = 4'b0101; glob_oe = 1'b1; core_oe = 4'b0010;
    #1;
    expect_now("R6 mixed source", 4'b1001, 4'b0111, 4'b0110, 4'b1010);

    // R8: spare codes
    @(negedge clk); #1;
    cfg_mode = m4(3'd7, 3'd6, 3'd5, 3'd5);
    core_oe = 4'hF; glob_oe = 1'b1; pad_in = 4'b0110;
    #1;
    expect_now("R8 spare codes", 4'b0110, 4'b0000, 4'b0000, 4'b1010);

    // Mixed lanes, R10 flag change
    @(negedge clk); #1;
    cfg_mode = m4(3'd6, 3'd4, 3'd3, 3'd0);
    cfg_oe_glob = 4'b0000; core_oe = 4'b0100; glob_oe = 1'b0;
    core_dout = 4'hF; pad_in = 4'b1010; cfg_slow = 4'b0101;
    #1;
    expect_now("R10 mixed lanes", 4'b1000, 4'b0110, 4'b0110, 4'b0101);

    // R9: reset in the middle of operation
    @(negedge clk); #1;
    cfg_mode = m4(3'd1, 3'd1, 3'd1, 3'd1); pad_in = 4'hF;
    @(posedge clk); #1;
    expect_now("R2 before reset", 4'b1111, 4'b0000, 4'b0000, 4'b0101);
    rst_n = 1'b0;
    #1;
    expect_now("R9 async clear flop", 4'b0000, 4'b0000, 4'b0000, 4'b0101);
    cfg_mode = m4(3'd2, 3'd1, 3'd2, 3'd1);
    @(posedge clk); #1;
    expect_now("R9 clear latch", 4'b0000, 4'b0000, 4'b0000, 4'b0101);

    #5;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule